// File: doc/BRIEF.md
# DMA Multi-Buffer Channel Sequencer

This block sequences one DMA channel that moves a run of buffers, one after another. Every buffer copies a number of words, one beat at a time, from a source region to a destination region. When a buffer finishes, the source address returns to the start value software programmed, so each buffer reads the same source block again. The destination runs in one of two modes. In contiguous mode it carries on from where the previous buffer stopped. In linked-list mode a four-word descriptor fetched from memory supplies a fresh destination, fresh control words and the pointer to the next descriptor.

Software programs the channel over a small write port while it is idle, then writes the start bit. The channel reports that it is busy, raises a sticky status bit after each buffer and another when the whole transfer ends, and then clears its own busy flag. All memory traffic goes through one request port with a request/acknowledge handshake: descriptor reads, status writebacks and the read-then-write pair of each beat.

Top module: `dma_mbuf_seq`

## Requirements
- R1: After synchronous reset `ch_active`, both status bits and `mem_req` are 0, and while `ch_active` is 0 no memory request is issued.
- R2: Register writes use `cfg_addr` 0 = source start, 1 = destination, 2 = control A, 3 = control B, 4 = descriptor pointer, and 5 with `cfg_wdata[0]`=1 = start. Writes are ignored while `ch_active` is 1, except writes to control B. `ch_active` reads 1 from the cycle after the start write until the transfer ends.
- R3: Each beat reads one word at the current source address and then writes it to the current destination address. Both addresses then advance by one word. The beats per buffer are control A bits [15:0].
- R4: After every buffer the source address reloads its programmed start value. In contiguous mode the next buffer's destination continues from the last one.
- R5: In contiguous mode (descriptor pointer 0 at start), control B bit 0 (auto) is sampled at the end of each buffer. If it is 1, another buffer follows with no software action. If it is 0, the transfer ends.
- R6: In linked-list mode (descriptor pointer nonzero at start), every buffer begins by reading four words at pointer+0..+3, which load in that order the destination, control A, control B and the next pointer.
- R7: After each linked-list buffer, control A with bit 31 set is written to pointer+1 of the current descriptor.
- R8: A linked-list transfer ends after the buffer whose next pointer is 0. Otherwise the next pointer becomes the current one. At the end of a transfer the transfer-done status sets in the same cycle that `ch_active` clears.
- R9: The status bits `stat_buf_done` (one per buffer) and `stat_xfer_done` are sticky, and a cycle with `stat_rd` high clears them. An event in the same cycle as `stat_rd` still leaves its bit set.
- R10: Once `mem_req` is raised, it stays high with `mem_we`, `mem_addr` and `mem_wdata` unchanged until a cycle with `mem_ack` high.
- R11: A buffer of length 0 moves no data but still completes. It raises the buffer status and, in linked-list mode, does its writeback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register select |
| cfg_wdata | input | DW | Register write data |
| stat_rd | input | 1 | Status read; clears the sticky bits |
| ch_active | output | 1 | Channel busy |
| stat_buf_done | output | 1 | Sticky buffer-complete status |
| stat_xfer_done | output | 1 | Sticky transfer-complete status |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | DW | Word address |
| mem_wdata | output | DW | Write data |
| mem_ack | input | 1 | Access accepted; read data valid this cycle |
| mem_rdata | input | DW | Read data |

## Verification
The bench's memory acknowledges every other cycle, so a design that drops or changes a request before the acknowledge loses or misroutes words. The second buffer of both multi-buffer runs must copy the same source block again. A design that forgets the reload copies the following words instead. A source write and a control-B write made while the channel is busy tell the control-B exception apart from the general write lock. A status read held through the final cycle must leave both bits set, which catches a design that lets the clear win. A zero-length buffer must not touch its destination word, and the descriptor words must carry the done bit and the exact length that was fetched.

// File: rtl/dmas_pkg.sv
package dmas_pkg;
    localparam int LEN_W    = 16;
    localparam int DONE_BIT = 31;
    localparam int AUTO_BIT = 0;

    localparam logic [2:0] RA_SRC  = 3'd0;
    localparam logic [2:0] RA_DST  = 3'd1;
    localparam logic [2:0] RA_CTLA = 3'd2;
    localparam logic [2:0] RA_CTLB = 3'd3;
    localparam logic [2:0] RA_DSCR = 3'd4;
    localparam logic [2:0] RA_GO   = 3'd5;

    typedef enum logic [2:0] {
        S_IDLE, S_FETCH, S_RD, S_WR, S_WB, S_END
    } seq_state_t;

    typedef struct packed {
        logic       fetch_we;
        logic [1:0] fetch_idx;
        logic       step;
        logic       reload;
        logic       follow;
    } hw_upd_t;

    function automatic logic [LEN_W:0] len_ext(input logic [LEN_W-1:0] v);
        return {1'b0, v};
    endfunction
endpackage

// File: rtl/dmas_chanregs.sv
module dmas_chanregs
    import dmas_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sw_we,
    input  logic [2:0]    sw_addr,
    input  logic [DW-1:0] sw_wdata,
    input  logic          busy,
    input  hw_upd_t       upd,
    input  logic [DW-1:0] fetch_data,
    output logic [DW-1:0] src_cur,
    output logic [DW-1:0] dst_cur,
    output logic [DW-1:0] ctla,
    output logic          auto_on,
    output logic [DW-1:0] dscr,
    output logic [DW-1:0] nxt,
    output logic          go
);
    logic [DW-1:0] src_start;

    assign go = sw_we && !busy && (sw_addr == RA_GO) && sw_wdata[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            src_start <= '0;
            src_cur   <= '0;
            dst_cur   <= '0;
            ctla      <= '0;
            auto_on   <= 1'b0;
            dscr      <= '0;
            nxt       <= '0;
        end else begin
            if (sw_we && !busy) begin
                case (sw_addr)
                    RA_SRC: begin
                        src_start <= sw_wdata;
                        src_cur   <= sw_wdata;
                    end
                    RA_DST:  dst_cur <= sw_wdata;
                    RA_CTLA: ctla    <= sw_wdata;
                    RA_DSCR: dscr    <= sw_wdata;
                    default: ;
                endcase
            end
            if (sw_we && sw_addr == RA_CTLB)
                auto_on <= sw_wdata[AUTO_BIT];
            if (upd.fetch_we) begin
                case (upd.fetch_idx)
                    2'd0: dst_cur <= fetch_data;
                    2'd1: ctla    <= fetch_data;
                    2'd2: auto_on <= fetch_data[AUTO_BIT];
                    default: nxt  <= fetch_data;
                endcase
            end
            if (upd.step) begin
                src_cur <= src_cur + DW'(1);
                dst_cur <= dst_cur + DW'(1);
            end
            if (upd.reload)
                src_cur <= src_start;
            if (upd.follow)
                dscr <= nxt;
        end
    end
endmodule

// File: rtl/dmas_ctl.sv
module dmas_ctl
    import dmas_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          go,
    input  logic [DW-1:0] src_cur,
    input  logic [DW-1:0] dst_cur,
    input  logic [DW-1:0] ctla,
    input  logic          auto_on,
    input  logic [DW-1:0] dscr,
    input  logic [DW-1:0] nxt,
    input  logic          mem_ack,
    input  logic [DW-1:0] mem_rdata,
    output logic          mem_req,
    output logic          mem_we,
    output logic [DW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output hw_upd_t       upd,
    output logic          busy,
    output logic          ev_buf,
    output logic          ev_xfer
);
    seq_state_t       state;
    logic [1:0]       idx;
    logic [LEN_W-1:0] cnt;
    logic             ll_mode;
    logic [DW-1:0]    beat_q;
    logic [LEN_W-1:0] len;
    logic             last_beat;
    logic             chain_on;

    assign len       = ctla[LEN_W-1:0];
    assign last_beat = (len_ext(cnt) + (LEN_W+1)'(1)) == len_ext(len);
    assign chain_on  = ll_mode && (nxt != '0);
    assign busy      = (state != S_IDLE);
    assign ev_buf    = (state == S_END);
    assign ev_xfer   = (state == S_END) && (ll_mode ? (nxt == '0) : !auto_on);

    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        case (state)
            S_FETCH: begin
                mem_req  = 1'b1;
                mem_addr = dscr + DW'(idx);
            end
            S_RD: begin
                mem_req  = 1'b1;
                mem_addr = src_cur;
            end
            S_WR: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = dst_cur;
                mem_wdata = beat_q;
            end
            S_WB: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = dscr + DW'(1);
                mem_wdata = ctla | (DW'(1) << DONE_BIT);
            end
            default: ;
        endcase
    end

    always_comb begin
        upd           = '0;
        upd.fetch_we  = (state == S_FETCH) && mem_ack;
        upd.fetch_idx = idx;
        upd.step      = (state == S_WR) && mem_ack;
        upd.reload    = (state == S_END);
        upd.follow    = (state == S_END) && chain_on;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= S_IDLE;
            idx     <= '0;
            cnt     <= '0;
            ll_mode <= 1'b0;
            beat_q  <= '0;
        end else begin
            case (state)
                S_IDLE: if (go) begin
                    ll_mode <= (dscr != '0);
                    idx     <= '0;
                    cnt     <= '0;
                    if (dscr != '0)        state <= S_FETCH;
                    else if (len == '0)    state <= S_END;
                    else                   state <= S_RD;
                end
                S_FETCH: if (mem_ack) begin
                    idx <= idx + 2'd1;
                    cnt <= '0;
                    if (idx == 2'd3)
                        state <= (len == '0) ? S_WB : S_RD;
                end
                S_RD: if (mem_ack) begin
                    beat_q <= mem_rdata;
                    state  <= S_WR;
                end
                S_WR: if (mem_ack) begin
                    cnt <= cnt + LEN_W'(1);
                    if (last_beat)
                        state <= ll_mode ? S_WB : S_END;
                    else
                        state <= S_RD;
                end
                S_WB: if (mem_ack) state <= S_END;
                S_END: begin
                    cnt <= '0;
                    idx <= '0;
                    if (ev_xfer)            state <= S_IDLE;
                    else if (ll_mode)       state <= S_FETCH;
                    else if (len == '0)     state <= S_END;
                    else                    state <= S_RD;
                end
                default: state <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/dmas_status.sv
module dmas_status (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic ev_buf,
    input  logic ev_xfer,
    output logic buf_done,
    output logic xfer_done
);
    always_ff @(posedge clk) begin
        if (rst) begin
            buf_done  <= 1'b0;
            xfer_done <= 1'b0;
        end else begin
            buf_done  <= (buf_done  && !clr) || ev_buf;
            xfer_done <= (xfer_done && !clr) || ev_xfer;
        end
    end
endmodule

// File: rtl/dma_mbuf_seq.sv
module dma_mbuf_seq
    import dmas_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_we,
    input  logic [2:0]    cfg_addr,
    input  logic [DW-1:0] cfg_wdata,
    input  logic          stat_rd,
    output logic          ch_active,
    output logic          stat_buf_done,
    output logic          stat_xfer_done,
    output logic          mem_req,
    output logic          mem_we,
    output logic [DW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic          mem_ack,
    input  logic [DW-1:0] mem_rdata
);
    hw_upd_t       upd;
    logic [DW-1:0] src_cur, dst_cur, ctla, dscr, nxt;
    logic          auto_on, go, ev_buf, ev_xfer;

    dmas_chanregs #(.DW(DW)) u_regs (
        .clk(clk), .rst(rst),
        .sw_we(cfg_we), .sw_addr(cfg_addr), .sw_wdata(cfg_wdata),
        .busy(ch_active), .upd(upd), .fetch_data(mem_rdata),
        .src_cur(src_cur), .dst_cur(dst_cur), .ctla(ctla),
        .auto_on(auto_on), .dscr(dscr), .nxt(nxt), .go(go)
    );

    dmas_ctl #(.DW(DW)) u_ctl (
        .clk(clk), .rst(rst), .go(go),
        .src_cur(src_cur), .dst_cur(dst_cur), .ctla(ctla),
        .auto_on(auto_on), .dscr(dscr), .nxt(nxt),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .upd(upd), .busy(ch_active),
        .ev_buf(ev_buf), .ev_xfer(ev_xfer)
    );

    dmas_status u_stat (
        .clk(clk), .rst(rst), .clr(stat_rd),
        .ev_buf(ev_buf), .ev_xfer(ev_xfer),
        .buf_done(stat_buf_done), .xfer_done(stat_xfer_done)
    );
endmodule

// File: rtl/dmas_chk.sv
module dmas_chk #(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          ch_active,
    input logic          mem_req,
    input logic          mem_ack,
    input logic          mem_we,
    input logic [DW-1:0] mem_addr,
    input logic [DW-1:0] mem_wdata,
    input logic          stat_rd,
    input logic          stat_buf_done,
    input logic          stat_xfer_done,
    input logic          ev_buf,
    input logic          ev_xfer
);
    assert_req_hold_R10: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_ack |=> mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata));

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        !ch_active |-> !mem_req);

    assert_end_status_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(ch_active) |-> stat_xfer_done);

    assert_xfer_stops_R8: assert property (@(posedge clk) disable iff (rst)
        ev_xfer |=> !ch_active);

    assert_read_clears_R9: assert property (@(posedge clk) disable iff (rst)
        stat_rd && !ev_buf |=> !stat_buf_done);

    assert_event_wins_R9: assert property (@(posedge clk) disable iff (rst)
        ev_buf |=> stat_buf_done);
endmodule

bind dma_mbuf_seq dmas_chk #(.DW(DW)) u_chk (
    .clk(clk), .rst(rst), .ch_active(ch_active),
    .mem_req(mem_req), .mem_ack(mem_ack), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .stat_rd(stat_rd),
    .stat_buf_done(stat_buf_done), .stat_xfer_done(stat_xfer_done),
    .ev_buf(ev_buf), .ev_xfer(ev_xfer)
);

// File: tb/dma_mbuf_seq_tb.sv
module dma_mbuf_seq_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_we;
    logic [2:0]  cfg_addr;
    logic [31:0] cfg_wdata;
    logic        stat_rd;
    logic        ch_active, stat_buf_done, stat_xfer_done;
    logic        mem_req, mem_we, mem_ack;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;

    logic [31:0] mem [256];
    logic        ack_q;
    logic        tb_wr;
    logic [7:0]  tb_waddr;
    logic [31:0] tb_wdata;

    int n_chk = 0;
    int n_err = 0;
    int hold_err = 0;
    int cyc = 0;

    always #10 clk = ~clk;

    dma_mbuf_seq #(.DW(32)) u_dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .stat_rd(stat_rd), .ch_active(ch_active),
        .stat_buf_done(stat_buf_done), .stat_xfer_done(stat_xfer_done),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    assign mem_ack   = ack_q;
    assign mem_rdata = mem[mem_addr[7:0]];

    always @(posedge clk) begin
        if (rst) ack_q <= 1'b0;
        else     ack_q <= mem_req && !ack_q;
        if (tb_wr)
            mem[tb_waddr] <= tb_wdata;
        else if (mem_req && mem_we && ack_q)
            mem[mem_addr[7:0]] <= mem_wdata;
    end

    // R10 monitor: request must be held unchanged until acknowledged
    logic        p_req = 1'b0, p_ack = 1'b0, p_we = 1'b0;
    logic [31:0] p_addr = '0, p_wdata = '0;
    always @(negedge clk) begin
        if (!rst && p_req && !p_ack &&
            (!mem_req || mem_we != p_we || mem_addr != p_addr || mem_wdata != p_wdata))
            hold_err++;
        p_req = mem_req; p_ack = mem_ack; p_we = mem_we;
        p_addr = mem_addr; p_wdata = mem_wdata;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: run hung act=%0d exp=<150000", cyc);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    function automatic logic [31:0] src_pat(input int a);
        return 32'hA500_0000 | 32'(a);
    endfunction
    function automatic logic [31:0] sent(input int a);
        return 32'h5E00_0000 | 32'(a);
    endfunction
    function automatic logic [31:0] init_word(input int a);
        return (a < 32) ? src_pat(a) : sent(a);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic mem_put(input int a, input logic [31:0] d);
        @(negedge clk);
        tb_wr = 1'b1; tb_waddr = 8'(a); tb_wdata = d;
        @(negedge clk);
        tb_wr = 1'b0;
    endtask

    task automatic mem_init();
        for (int a = 0; a < 256; a++) mem_put(a, init_word(a));
    endtask

    task automatic set_reg(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic wait_idle(input string tag);
        int n = 0;
        while (ch_active && n < 5000) begin
            @(negedge clk);
            n++;
        end
        if (n >= 5000) chk({tag, " timeout"}, 32'(ch_active), 32'd0);
    endtask

    task automatic clear_stat();
        @(negedge clk); stat_rd = 1'b1;
        @(negedge clk); stat_rd = 1'b0;
    endtask

    // table: {src[7:0], dst[7:0], len[7:0]}, contiguous mode, auto off
    localparam logic [23:0] VECS [4] = '{
        24'h00_A0_04, 24'h05_B0_01, 24'h10_C0_07, 24'h1E_D0_03
    };

    initial begin
        rst = 1'b1; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
        stat_rd = 1'b0; tb_wr = 1'b0; tb_waddr = '0; tb_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 ch_active", 32'(ch_active), 32'd0);
        chk("R1 stat_buf_done", 32'(stat_buf_done), 32'd0);
        chk("R1 stat_xfer_done", 32'(stat_xfer_done), 32'd0);
        chk("R1 mem_req", 32'(mem_req), 32'd0);

        // R3 table of contiguous single-buffer copies
        for (int v = 0; v < 4; v++) begin
            int s = int'(VECS[v][23:16]);
            int d = int'(VECS[v][15:8]);
            int l = int'(VECS[v][7:0]);
            mem_init();
            set_reg(3'd0, 32'(s));
            set_reg(3'd1, 32'(d));
            set_reg(3'd2, 32'(l));
            set_reg(3'd3, 32'd0);
            set_reg(3'd4, 32'd0);
            set_reg(3'd5, 32'd1);
            chk("R2 active after start", 32'(ch_active), 32'd1);
            wait_idle("R3 table");
            for (int i = 0; i < l; i++)
                chk("R3 copied word", mem[8'(d + i)], init_word(s + i));
            chk("R3 word past end untouched", mem[8'(d + l)], sent(d + l));
            chk("R8 xfer done", 32'(stat_xfer_done), 32'd1);
            chk("R9 buf done sticky", 32'(stat_buf_done), 32'd1);
            clear_stat();
            chk("R9 cleared by read", {30'd0, stat_buf_done, stat_xfer_done}, 32'd0);
        end

        // R6 R7 R4 R8 linked-list destination, two descriptors
        mem_init();
        mem_put(8'h80, 32'h40); mem_put(8'h81, 32'd3);
        mem_put(8'h82, 32'd0);  mem_put(8'h83, 32'h84);
        mem_put(8'h84, 32'h50); mem_put(8'h85, 32'd2);
        mem_put(8'h86, 32'd0);  mem_put(8'h87, 32'd0);
        set_reg(3'd0, 32'h00);
        set_reg(3'd1, 32'h99);
        set_reg(3'd2, 32'd9);
        set_reg(3'd4, 32'h80);
        set_reg(3'd5, 32'd1);
        wait_idle("R6 list");
        for (int i = 0; i < 3; i++)
            chk("R6 first descriptor dest", mem[8'(8'h40 + i)], src_pat(i));
        for (int i = 0; i < 2; i++)
            chk("R4 source reloaded for second buffer", mem[8'(8'h50 + i)], src_pat(i));
        chk("R6 second buffer length from descriptor", mem[8'h52], sent(8'h52));
        chk("R6 programmed dest unused", mem[8'h99], sent(8'h99));
        chk("R7 writeback first", mem[8'h81], 32'h8000_0003);
        chk("R7 writeback second", mem[8'h85], 32'h8000_0002);
        chk("R8 list end xfer done", 32'(stat_xfer_done), 32'd1);
        clear_stat();

        // R5 R4 R2 contiguous with auto, cleared mid-run by a control-B write
        mem_init();
        set_reg(3'd0, 32'h10);
        set_reg(3'd1, 32'h60);
        set_reg(3'd2, 32'd3);
        set_reg(3'd3, 32'd1);
        set_reg(3'd4, 32'd0);
        set_reg(3'd5, 32'd1);
        set_reg(3'd0, 32'h20);   // ignored while busy (R2)
        begin
            int n = 0;
            while (!stat_buf_done && n < 5000) begin @(negedge clk); n++; end
        end
        chk("R5 still active after first buffer", 32'(ch_active), 32'd1);
        set_reg(3'd3, 32'd0);    // control B accepted while busy (R2)
        wait_idle("R5 auto");
        for (int i = 0; i < 3; i++) begin
            chk("R5 first buffer", mem[8'(8'h60 + i)], src_pat(16 + i));
            chk("R4 contiguous dest, reloaded source", mem[8'(8'h63 + i)], src_pat(16 + i));
        end
        chk("R5 stops after auto cleared", mem[8'h66], sent(8'h66));
        clear_stat();

        // R9 status read held through the final event
        mem_init();
        set_reg(3'd0, 32'h00);
        set_reg(3'd1, 32'h30);
        set_reg(3'd2, 32'd2);
        set_reg(3'd3, 32'd0);
        @(negedge clk); stat_rd = 1'b1;
        set_reg(3'd5, 32'd1);
        wait_idle("R9 collision");
        chk("R9 event wins over read (buf)", 32'(stat_buf_done), 32'd1);
        chk("R9 event wins over read (xfer)", 32'(stat_xfer_done), 32'd1);
        @(negedge clk);
        chk("R9 next read clears", {30'd0, stat_buf_done, stat_xfer_done}, 32'd0);
        stat_rd = 1'b0;

        // R11 zero-length contiguous buffer
        set_reg(3'd1, 32'h70);
        set_reg(3'd2, 32'd0);
        set_reg(3'd5, 32'd1);
        wait_idle("R11 zero");
        chk("R11 no data moved", mem[8'h70], sent(8'h70));
        chk("R11 buffer status", 32'(stat_buf_done), 32'd1);
        chk("R11 transfer ends", 32'(stat_xfer_done), 32'd1);
        clear_stat();

        chk("R10 request held until ack", 32'(hold_err), 32'd0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule